// File: doc/BRIEF.md
# Speculative Load Address Check Table

A small associative table that lets a compiler move a load above stores that might alias it. When the hoisted load executes, the table records the double-word address it read under a tag that names that load, for example its destination register number. Every store that executes afterwards presents its address, and any recorded entry covering the same double-word is invalidated. A check operation, placed where the load originally stood, then looks up the tag: a live entry means no store touched the location and the speculation held; a missing entry means it failed and recovery code must run.

The table holds a fixed number of entries. A new speculative load whose tag is already present replaces that entry. When the table is full, a round-robin pointer picks the victim. A successful check frees its entry. Conflicts between operations in the same cycle follow a fixed order, described in the requirements below.

Top module: `specld_table`

## Requirements
- R1: After reset every entry is invalid, so a check of any tag reports failure.
- R2: A check is answered exactly one cycle after it is presented. `resValid` is high for that one cycle, and `resPass` is 1 when the tag holds a live entry.
- R3: A store whose address matches a live entry in bits [ADDR_W-1:3] invalidates that entry, so a later check of its tag fails. A store to a different double-word leaves the entry live.
- R4: A check of a tag with no live entry reports failure.
- R5: A check that passes frees its entry, so a second check of the same tag fails.
- R6: An allocation whose tag matches a live entry overwrites that entry's address. A store to the old address then has no effect on the tag.
- R7: An allocation with a new tag takes the lowest-numbered free entry. When there is no free entry, it evicts the entry at a round-robin pointer, which starts at 0 after reset and advances by one, wrapping, on each eviction only. A later check of the evicted tag fails.
- R8: When a store and an allocation to the same double-word occur in the same cycle, the new entry stays live.
- R9: When a store and a check occur in the same cycle, the store is applied first, so a check whose entry the store hits reports failure.
- R10: When a check and an allocation with the same tag occur in the same cycle, the check is answered from the entry as it stood before. The new allocation then remains live, even if the check passed.
- R11: `resPass` is 0 in every cycle in which `resValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | A speculative load executes this cycle |
| allocTag | input | TAG_W | Tag naming the speculative load |
| allocAddr | input | ADDR_W | Byte address the load accessed |
| storeValid | input | 1 | A store executes this cycle |
| storeAddr | input | ADDR_W | Byte address written by the store |
| checkValid | input | 1 | A check operation executes this cycle |
| checkTag | input | TAG_W | Tag the check looks up |
| resValid | output | 1 | Check result is present |
| resPass | output | 1 | 1 = speculation held, 0 = failed |

## Verification
The only output is the check result, which is registered once, so each check's verdict appears on the first clock edge after it is presented. The effect of an allocation or a store on the table appears one edge later still, through the next check. The bench drives the inputs on the falling edge. It steps a behavioural model of the table once per cycle, on the same falling edge, and compares both result bits on the next falling edge, where the registered answer has settled. Directed sequences cover each ordering rule for operations in the same cycle and the eviction order. A long run of random operations over a small set of tags and addresses then exercises mixed traffic against the same model.

// File: rtl/specld_pkg.sv
package specld_pkg;
  // Slot index width used by the control-to-datapath strobes (up to 256 entries).
  localparam int SLOT_IDX_W = 8;

  typedef struct packed {
    logic                  allocWe;
    logic [SLOT_IDX_W-1:0] allocSlot;
    logic                  checkClr;
    logic [SLOT_IDX_W-1:0] checkSlot;
  } slotStrobe_t;
endpackage

// File: rtl/specld_dp.sv
module specld_dp
  import specld_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int TAG_W       = 5,
  parameter int ADDR_W      = 32,
  parameter int GRAIN_LOG2  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  slotStrobe_t            strb,
  input  logic [TAG_W-1:0]       allocTag,
  input  logic [ADDR_W-1:0]      allocAddr,
  input  logic                   storeValid,
  input  logic [ADDR_W-1:0]      storeAddr,
  input  logic [TAG_W-1:0]       checkTag,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] allocHitVec,
  output logic [NUM_ENTRIES-1:0] checkHitVec,
  output logic [NUM_ENTRIES-1:0] storeHitVec
);
  localparam int LINE_W = ADDR_W - GRAIN_LOG2;

  logic [TAG_W-1:0]  tagQ  [NUM_ENTRIES];
  logic [LINE_W-1:0] lineQ [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validQ;

  assign validVec = validQ;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      allocHitVec[i] = validQ[i] && (tagQ[i] == allocTag);
      checkHitVec[i] = validQ[i] && (tagQ[i] == checkTag);
      storeHitVec[i] = validQ[i] && storeValid &&
                       (lineQ[i] == storeAddr[ADDR_W-1:GRAIN_LOG2]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagQ[i]  <= '0;
        lineQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strb.allocWe && strb.allocSlot == SLOT_IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          tagQ[i]   <= allocTag;
          lineQ[i]  <= allocAddr[ADDR_W-1:GRAIN_LOG2];
        end else if (storeHitVec[i] ||
                     (strb.checkClr && strb.checkSlot == SLOT_IDX_W'(i))) begin
          validQ[i] <= 1'b0;
        end
      end
    end
  end

  // Per-entry checks on the table state.
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entryChk
    a_r7_alloc_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.allocWe && strb.allocSlot == SLOT_IDX_W'(g)) |=> validQ[g]);
    a_r3_store_kills: assert property (@(posedge clk) disable iff (!rst_n)
      (storeHitVec[g] && !(strb.allocWe && strb.allocSlot == SLOT_IDX_W'(g)))
        |=> !validQ[g]);
    for (genvar h = g + 1; h < NUM_ENTRIES; h++) begin : g_pair
      a_r6_unique_tags: assert property (@(posedge clk) disable iff (!rst_n)
        !(validQ[g] && validQ[h] && tagQ[g] == tagQ[h]));
    end
  end
endmodule

// File: rtl/specld_ctrl.sv
module specld_ctrl
  import specld_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   allocValid,
  input  logic                   checkValid,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] allocHitVec,
  input  logic [NUM_ENTRIES-1:0] checkHitVec,
  input  logic [NUM_ENTRIES-1:0] storeHitVec,
  output slotStrobe_t            strb,
  output logic                   resValid,
  output logic                   resPass
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [IDX_W-1:0]      rrPtr;
  logic                  hitAny, freeAny, liveAny, evict;
  logic [SLOT_IDX_W-1:0] hitIdx, freeIdx, liveIdx;

  always_comb begin
    hitAny = 1'b0; hitIdx = '0;
    freeAny = 1'b0; freeIdx = '0;
    liveAny = 1'b0; liveIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!hitAny && allocHitVec[i]) begin
        hitAny = 1'b1; hitIdx = SLOT_IDX_W'(i);
      end
      if (!freeAny && !validVec[i]) begin
        freeAny = 1'b1; freeIdx = SLOT_IDX_W'(i);
      end
      // Store is applied before the check: a hit entry the store also hits is dead.
      if (!liveAny && checkHitVec[i] && !storeHitVec[i]) begin
        liveAny = 1'b1; liveIdx = SLOT_IDX_W'(i);
      end
    end
  end

  always_comb begin
    evict          = allocValid && !hitAny && !freeAny;
    strb.allocWe   = allocValid;
    strb.allocSlot = hitAny ? hitIdx : (freeAny ? freeIdx : SLOT_IDX_W'(rrPtr));
    strb.checkClr  = checkValid && liveAny;
    strb.checkSlot = liveIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrPtr    <= '0;
      resValid <= 1'b0;
      resPass  <= 1'b0;
    end else begin
      resValid <= checkValid;
      resPass  <= checkValid && liveAny;
      if (evict)
        rrPtr <= (rrPtr == IDX_W'(NUM_ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    checkValid |=> resValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !checkValid |=> !resValid);
  a_r11_pass_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    resPass |-> resValid);
  a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(checkHitVec));
  a_r7_rr_range: assert property (@(posedge clk) disable iff (!rst_n)
    rrPtr <= IDX_W'(NUM_ENTRIES - 1));
  a_r7_rr_moves_on_evict: assert property (@(posedge clk) disable iff (!rst_n)
    !evict |=> $stable(rrPtr));
endmodule

// File: rtl/specld_table.sv
module specld_table
  import specld_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int TAG_W       = 5,
  parameter int ADDR_W      = 32,
  parameter int GRAIN_LOG2  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allocValid,
  input  logic [TAG_W-1:0]  allocTag,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              storeValid,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic              checkValid,
  input  logic [TAG_W-1:0]  checkTag,
  output logic              resValid,
  output logic              resPass
);
  slotStrobe_t            strb;
  logic [NUM_ENTRIES-1:0] validVec, allocHitVec, checkHitVec, storeHitVec;

  specld_dp #(
    .NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W),
    .ADDR_W(ADDR_W), .GRAIN_LOG2(GRAIN_LOG2)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .allocTag(allocTag), .allocAddr(allocAddr),
    .storeValid(storeValid), .storeAddr(storeAddr),
    .checkTag(checkTag),
    .validVec(validVec), .allocHitVec(allocHitVec),
    .checkHitVec(checkHitVec), .storeHitVec(storeHitVec)
  );

  specld_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .checkValid(checkValid),
    .validVec(validVec), .allocHitVec(allocHitVec),
    .checkHitVec(checkHitVec), .storeHitVec(storeHitVec),
    .strb(strb), .resValid(resValid), .resPass(resPass)
  );
endmodule

// File: tb/sim_specld_table.sv
module sim_specld_table;
  localparam int N = 4;
  localparam int TW = 5;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic allocValid = 1'b0, storeValid = 1'b0, checkValid = 1'b0;
  logic [TW-1:0] allocTag = '0, checkTag = '0;
  logic [AW-1:0] allocAddr = '0, storeAddr = '0;
  logic resValid, resPass;

  always #10 clk = ~clk;

  specld_table #(.NUM_ENTRIES(N), .TAG_W(TW), .ADDR_W(AW), .GRAIN_LOG2(3)) u0 (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocTag(allocTag), .allocAddr(allocAddr),
    .storeValid(storeValid), .storeAddr(storeAddr),
    .checkValid(checkValid), .checkTag(checkTag),
    .resValid(resValid), .resPass(resPass)
  );

  // Behavioural model state.
  bit     mLive [N];
  int     mTag  [N];
  longint mLine [N];
  int     mRr;
  bit     expValid, expPass;
  string  expReq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  task automatic compare();
    vectors++;
    if (resValid !== expValid || resPass !== expPass) begin
      errors++;
      $display("FAIL %s: resValid/resPass = %b/%b, expected %b/%b at %0t",
               expReq, resValid, resPass, expValid, expPass, $time);
    end
  endtask

  // One cycle: check the previous answer, drive new inputs, step the model.
  task automatic step(input bit aV, input int aT, input longint aA,
                      input bit sV, input longint sA,
                      input bit cV, input int cT, input string req);
    int  cIdx, hIdx, fIdx, slot;
    bit  pass;
    @(negedge clk);
    compare();
    allocValid = aV; allocTag = TW'(aT); allocAddr = AW'(aA);
    storeValid = sV; storeAddr = AW'(sA);
    checkValid = cV; checkTag  = TW'(cT);
    cIdx = -1; hIdx = -1; fIdx = -1;
    for (int i = 0; i < N; i++) begin
      if (mLive[i] && mTag[i] == cT) cIdx = i;
      if (mLive[i] && mTag[i] == aT) hIdx = i;
      if (!mLive[i] && fIdx < 0) fIdx = i;
    end
    pass = cV && cIdx >= 0 && !(sV && mLine[cIdx] == (sA >> 3));
    expValid = cV;
    expPass  = pass;
    expReq   = cV ? req : "R11";
    for (int i = 0; i < N; i++) begin
      if (mLive[i] && sV && mLine[i] == (sA >> 3)) mLive[i] = 1'b0;
    end
    if (pass) mLive[cIdx] = 1'b0;
    if (aV) begin
      if (hIdx >= 0) slot = hIdx;
      else if (fIdx >= 0) slot = fIdx;
      else begin
        slot = mRr;
        mRr = (mRr + 1) % N;
      end
      mLive[slot] = 1'b1; mTag[slot] = aT; mLine[slot] = aA >> 3;
    end
  endtask

  task automatic alloc(input int t, input longint a, input string r);
    step(1, t, a, 0, 0, 0, 0, r);
  endtask
  task automatic store(input longint a, input string r);
    step(0, 0, 0, 1, a, 0, 0, r);
  endtask
  task automatic check(input int t, input string r);
    step(0, 0, 0, 0, 0, 1, t, r);
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, "R11");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mLive[i] = 1'b0; mTag[i] = 0; mLine[i] = 0;
    end
    mRr = 0; expValid = 1'b0; expPass = 1'b0; expReq = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then a check right after reset fails.
    idle();
    check(3, "R1");
    idle();
    // R2: alloc then check passes; R5: second check fails.
    alloc(1, 'h100, "R2");
    idle();
    check(1, "R2");
    check(1, "R5");
    // R3: store in same double-word kills; other double-word does not.
    alloc(2, 'h200, "R3");
    store('h204, "R3");
    check(2, "R3");
    alloc(3, 'h300, "R3");
    store('h308, "R3");
    check(3, "R3");
    // R4: absent tag.
    check(9, "R4");
    // R6: same-tag realloc overwrites address.
    alloc(4, 'h400, "R6");
    alloc(4, 'h500, "R6");
    store('h400, "R6");
    check(4, "R6");
    // R7: fill, lowest free, round-robin eviction.
    alloc(10, 'h1000, "R7");
    alloc(11, 'h1100, "R7");
    alloc(12, 'h1200, "R7");
    alloc(13, 'h1300, "R7");
    alloc(14, 'h1400, "R7");
    check(10, "R7");
    check(11, "R7");
    alloc(15, 'h1500, "R7");
    alloc(17, 'h1700, "R7");
    check(15, "R7");
    check(12, "R7");
    check(14, "R7");
    // R8: store and alloc to the same double-word together.
    step(1, 20, 'h700, 1, 'h700, 0, 0, "R8");
    check(20, "R8");
    // R9: store and check together, store first.
    alloc(21, 'h800, "R9");
    step(0, 0, 0, 1, 'h800, 1, 21, "R9");
    check(21, "R9");
    // R10: check and alloc with the same tag together.
    alloc(22, 'h900, "R10");
    step(1, 22, 'hA00, 0, 0, 1, 22, "R10");
    store('h900, "R10");
    check(22, "R10");
    // Mixed random traffic over a small tag and address space.
    for (int k = 0; k < 3000; k++) begin
      step($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 15) * 4,
           $urandom_range(0, 1), $urandom_range(0, 15) * 4,
           $urandom_range(0, 1), $urandom_range(0, 7), "R2");
    end
    idle();
    idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule